// File: doc/BRIEF.md
# Oversampling Accumulate-and-Dump Resolution Enhancer

This block trades sample rate for resolution. It takes a stream of 14-bit unsigned converter samples, each qualified by a valid strobe, and adds them up in batches of 4^n samples. When a batch is complete it emits one wider output word and a one-cycle valid pulse. Averaging 4^n samples suppresses random quantization noise enough to gain n effective bits. The block therefore keeps the batch sum scaled down by n bits rather than dividing it by the full batch size.

The shift setting n is static in normal use and may be any value from 0 up to the parameter limit. The default limit is 8, which gives batches of 65,536 samples and a 22-bit output. The accumulator is sized for the largest batch, so it cannot wrap. A new setting is taken up only at the start of a batch. Idle cycles, where valid is low, neither advance nor disturb a batch.

Top module: `ovs_enhancer`

## Requirements
- R1: A synchronous reset clears the output word to zero, clears the output valid, and discards any partly summed batch. The first batch after reset is a full batch.
- R2: A sample is taken only on a cycle where `sampleValid` is 1. Idle cycles do not count toward the batch and do not change the sum.
- R3: A batch holds exactly 4^n accepted samples. `resultValid` is 1 for exactly the one cycle that follows the clock edge at which the last sample of the batch is accepted, and it is 0 at all other times.
- R4: Samples are unsigned binary. The output equals the sum of the batch's samples shifted right by n bits, zero-extended to 14+MAX_SHIFT bits. A constant input x gives x·2^n.
- R5: The sum never overflows. With n=MAX_SHIFT and every sample at full scale 16383, the output is 16383·2^MAX_SHIFT (4,194,048 by default).
- R6: While valid stays high continuously, the sample after a completing sample is the first sample of the next batch. No sample is dropped at a batch boundary.
- R7: The n used for a batch is the `shiftSel` value present on the cycle that accepts the batch's first sample. Changes to `shiftSel` later in the batch affect only the following batches.
- R8: A `shiftSel` value above MAX_SHIFT is treated as MAX_SHIFT.
- R9: With n=0, every accepted sample produces an output pulse carrying that sample unchanged.
- R10: Between pulses, `resultOut` holds the last emitted value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sampleIn | input | 14 | Unsigned converter sample |
| sampleValid | input | 1 | Qualifies `sampleIn` for this cycle |
| shiftSel | input | 4 | Resolution gain n; the batch size is 4^n |
| resultOut | output | 22 | Batch sum shifted right by n |
| resultValid | output | 1 | One-cycle pulse when a batch completes |

## Verification
Closing one batch and opening the next can fall in the same cycle. The same is true of taking up a new `shiftSel` value. Both cases arise when valid stays high across the boundary, or when n is 0. The bench provokes them with unbroken valid runs and with `shiftSel` changed at random every cycle, including on completing cycles. A reference model fixes n at each batch's first accepted sample. The bench judges each pulse by its exact sum, which shows whether a boundary sample was dropped, counted twice, or scaled with the wrong n.

// File: rtl/ovs_pkg.sv
package ovs_pkg;
  // Strobes from the batch control to the datapath.
  typedef struct packed {
    logic take;   // accept sampleIn this cycle
    logic dump;   // this sample completes the batch
  } ovsStrobe_t;
endpackage

// File: rtl/ovs_ctrl.sv
module ovs_ctrl
  import ovs_pkg::*;
#(
  parameter int MAX_SHIFT = 8,
  parameter int SEL_W     = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sampleValid,
  input  logic [SEL_W-1:0] shiftSel,
  output ovsStrobe_t       strobe,
  output logic [SEL_W-1:0] batchShift
);
  localparam int CNT_W = 2 * MAX_SHIFT + 1;

  logic [CNT_W-1:0] count;
  logic [SEL_W-1:0] activeShift;
  logic [SEL_W-1:0] selClamped;
  logic [CNT_W-1:0] lastIdx;
  logic             atStart;

  // R8: out-of-range selections saturate to the limit
  assign selClamped = (shiftSel > SEL_W'(MAX_SHIFT)) ? SEL_W'(MAX_SHIFT) : shiftSel;
  assign atStart    = (count == '0);
  // R7: n is free to follow the input only before the first sample of a batch
  assign batchShift = atStart ? selClamped : activeShift;
  assign lastIdx    = (CNT_W'(1) << {batchShift, 1'b0}) - CNT_W'(1);

  assign strobe.take = sampleValid;
  assign strobe.dump = sampleValid && (count == lastIdx);

  always_ff @(posedge clk) begin
    if (rst) begin
      count       <= '0;
      activeShift <= '0;
    end else begin
      if (strobe.take && atStart) activeShift <= selClamped;
      if (strobe.dump)            count <= '0;
      else if (strobe.take)       count <= count + CNT_W'(1);
    end
  end

  AST_SHIFT_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (!atStart && !strobe.dump) |=> $stable(activeShift)); // R7
  AST_SHIFT_CLAMP: assert property (@(posedge clk) disable iff (rst)
    activeShift <= SEL_W'(MAX_SHIFT)); // R8
  AST_COUNT_RANGE: assert property (@(posedge clk) disable iff (rst)
    !atStart |-> (count <= ((CNT_W'(1) << {activeShift, 1'b0}) - CNT_W'(1)))); // R3
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !sampleValid |=> $stable(count)); // R2
endmodule

// File: rtl/ovs_datapath.sv
module ovs_datapath
  import ovs_pkg::*;
#(
  parameter int SAMPLE_W  = 14,
  parameter int MAX_SHIFT = 8,
  parameter int SEL_W     = 4
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [SAMPLE_W-1:0]           sampleIn,
  input  ovsStrobe_t                    strobe,
  input  logic [SEL_W-1:0]              batchShift,
  output logic [SAMPLE_W+MAX_SHIFT-1:0] resultOut,
  output logic                          resultValid
);
  localparam int ACC_W = SAMPLE_W + 2 * MAX_SHIFT;
  localparam int OUT_W = SAMPLE_W + MAX_SHIFT;

  logic [ACC_W-1:0] acc;
  logic [ACC_W:0]   sumWide;

  // One spare top bit exposes any wrap to the overflow check
  assign sumWide = {1'b0, acc} + (ACC_W + 1)'(sampleIn);

  always_ff @(posedge clk) begin
    if (rst) begin
      acc         <= '0;
      resultOut   <= '0;
      resultValid <= 1'b0;
    end else begin
      resultValid <= strobe.dump;
      if (strobe.dump) begin
        acc       <= '0;
        resultOut <= OUT_W'(sumWide >> batchShift);
      end else if (strobe.take) begin
        acc <= sumWide[ACC_W-1:0];
      end
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    strobe.take |-> !sumWide[ACC_W]); // R5
  AST_ACC_RESTART: assert property (@(posedge clk) disable iff (rst)
    strobe.dump |=> (acc == '0)); // R6
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !strobe.dump |=> $stable(resultOut)); // R10
endmodule

// File: rtl/ovs_enhancer.sv
module ovs_enhancer
  import ovs_pkg::*;
#(
  parameter int SAMPLE_W  = 14,
  parameter int MAX_SHIFT = 8,
  parameter int SEL_W     = (MAX_SHIFT < 1) ? 1 : $clog2(MAX_SHIFT + 1)
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [SAMPLE_W-1:0]           sampleIn,
  input  logic                          sampleValid,
  input  logic [SEL_W-1:0]              shiftSel,
  output logic [SAMPLE_W+MAX_SHIFT-1:0] resultOut,
  output logic                          resultValid
);
  ovsStrobe_t       strobe;
  logic [SEL_W-1:0] batchShift;

  ovs_ctrl #(.MAX_SHIFT(MAX_SHIFT), .SEL_W(SEL_W)) i_ctrl (
    .clk(clk), .rst(rst), .sampleValid(sampleValid), .shiftSel(shiftSel),
    .strobe(strobe), .batchShift(batchShift)
  );

  ovs_datapath #(.SAMPLE_W(SAMPLE_W), .MAX_SHIFT(MAX_SHIFT), .SEL_W(SEL_W)) i_dp (
    .clk(clk), .rst(rst), .sampleIn(sampleIn), .strobe(strobe),
    .batchShift(batchShift), .resultOut(resultOut), .resultValid(resultValid)
  );

  AST_PULSE_NEEDS_SAMPLE: assert property (@(posedge clk) disable iff (rst)
    resultValid |-> $past(sampleValid)); // R3
endmodule

// File: tb/test_ovs_enhancer.sv
module test_ovs_enhancer;
  localparam int CLK_PERIOD = 10;
  localparam int MAXN = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [13:0] sampleIn = '0;
  logic        sampleValid = 1'b0;
  logic [3:0]  shiftSel = '0;
  logic [21:0] resultOut;
  logic        resultValid;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  string curTag = "R1";

  // reference model state
  longint mSum = 0;
  int     mCount = 0;
  int     mN = 0;
  longint mOut = 0;

  ovs_enhancer i_ovs_enhancer (
    .clk(clk), .rst(rst), .sampleIn(sampleIn), .sampleValid(sampleValid),
    .shiftSel(shiftSel), .resultOut(resultOut), .resultValid(resultValid)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int clampN(input int s);
    return (s > MAXN) ? MAXN : s;
  endfunction

  task automatic check(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // One clock: drive at falling edge, update model, sample after rising edge
  task automatic step(input bit v, input int s);
    bit expV;
    @(negedge clk);
    sampleValid = v;
    sampleIn = 14'(s);
    expV = 0;
    if (v) begin
      if (mCount == 0) mN = clampN(int'(shiftSel));
      mSum += s;
      mCount++;
      if (mCount == (1 << (2 * mN))) begin
        expV = 1;
        mOut = mSum >> mN;
        mSum = 0;
        mCount = 0;
      end
    end
    @(posedge clk);
    #1;
    check(curTag, resultValid, expV);
    check(expV ? curTag : "R10", resultOut, mOut);
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1;
    sampleValid = 1'b0;
    @(posedge clk); @(posedge clk);
    #1;
    mSum = 0; mCount = 0; mOut = 0;
    check("R1", resultValid, 0);
    check("R1", resultOut, 0);
    @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    curTag = "R1";
    doReset();

    // R9: n=0 passes every sample through
    curTag = "R9";
    shiftSel = 4'd0;
    for (int i = 0; i < 30; i++) step(($urandom % 3) != 0, $urandom & 16'h3fff);

    // R2: idle cycles mixed in at n=1
    curTag = "R2";
    shiftSel = 4'd1;
    for (int i = 0; i < 200; i++) step(($urandom % 4) != 0, $urandom & 16'h3fff);

    // R4: constant input gives x*2^n
    curTag = "R4";
    shiftSel = 4'd2;
    for (int i = 0; i < 48; i++) step(1'b1, 1234);
    check("R4", resultOut, 1234 * 4);

    // R6: unbroken valid across boundaries
    curTag = "R6";
    shiftSel = 4'd1;
    for (int i = 0; i < 80; i++) step(1'b1, $urandom & 16'h3fff);

    // R7: change mid-batch, then random changes every cycle
    curTag = "R7";
    shiftSel = 4'd2;
    for (int i = 0; i < 5; i++) step(1'b1, 100 + i);
    shiftSel = 4'd1;
    for (int i = 0; i < 11; i++) step(1'b1, 200 + i);
    for (int i = 0; i < 8; i++) step(1'b1, 300 + i);
    for (int i = 0; i < 400; i++) begin
      shiftSel = 4'($urandom % 3);
      step(($urandom % 5) != 0, $urandom & 16'h3fff);
    end

    // R3: sparse valid, exact pulse count per batch
    curTag = "R3";
    shiftSel = 4'd1;
    for (int i = 0; i < 60; i++) step(($urandom % 2) != 0, $urandom & 16'h3fff);

    // R1: reset in mid-batch drops partial sum
    shiftSel = 4'd1;
    for (int i = 0; i < 3; i++) step(1'b1, 5000);
    curTag = "R1";
    doReset();
    for (int i = 0; i < 4; i++) step(1'b1, 10 * (i + 1));
    check("R1", resultOut, 50);

    // R5 + R8: out-of-range select saturates, full-scale largest batch
    curTag = "R8";
    shiftSel = 4'd15;
    for (int i = 0; i < 65536; i++) step(1'b1, 16383);
    check("R5", resultOut, 64'd4194048);
    step(1'b0, 0);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule